// File: doc/BRIEF.md
# Pending Interrupt Prioritiser with End-of-Interrupt Lookup

This block keeps three bit vectors for a set of interrupt pins: a pending-request vector, an in-service vector and, taken from its input, a mask vector. At any cycle it offers the highest-numbered pin that is pending, not in service and not masked to the delivery logic over a valid/ready handshake. Each completed handshake retires one pin. Its request bit is cleared. If the pin is configured as level-triggered, it is also placed in service, which blocks it until an end-of-interrupt arrives.

An end-of-interrupt carries a vector value, not a pin number. The block searches the per-pin vector settings and picks the lowest-indexed matching pin, leaving out the last pin. It clears that pin's in-service bit. Pin inputs are converted to request events according to each pin's trigger mode. Two bit-vector strobes allow requests to be raised or dropped in bulk. The offer is combinational from the request, in-service and mask state, so the delivery logic reads the pin number in the cycle it accepts.

Top module: `irq_prio_eoi`

## Requirements
- R1: A pin is eligible when its request bit is set and both its in-service bit and its mask bit are clear. `dlv_valid` is high exactly when some pin is eligible, and `dlv_pin` then gives the highest-numbered eligible pin.
- R2: A clock edge with `dlv_valid` and `dlv_ready` both high clears the request bit of the offered pin. The next pin is offered in the cycle after, so one pin is retired per handshake.
- R3: A retired pin whose trigger-mode bit is 1 (level) enters service and is not offered again until an end-of-interrupt releases it. A retired pin whose trigger-mode bit is 0 (edge) does not enter service.
- R4: For a level pin, a rising input sets its request bit and a falling input clears it.
- R5: For an edge pin, a rising input sets its request bit and a falling input leaves the request bit unchanged.
- R6: Pin input transitions are ignored while `enable` is low or the pin's mask bit is set, and they are not recalled when either condition is lifted later.
- R7: A bulk-set strobe bit sets the request bit only of an unmasked pin. A bulk-clear strobe bit clears the request bit whatever the mask is. When both bits hit the same pin in one cycle, the clear is applied first and the set wins.
- R8: An end-of-interrupt strobe picks the lowest-indexed pin among pins 0 to NPINS-2 whose vector field (`VEC_W` bits, pin i at bits i*VEC_W upward in `pin_vec`) equals `eoi_vec`. If that pin is in service, the strobe clears its in-service bit.
- R9: An end-of-interrupt is ignored when no pin among 0 to NPINS-2 matches, or when the lowest match is not in service, even if another matching pin is in service. The last pin is never released by an end-of-interrupt.
- R10: After reset the request and in-service vectors are empty, so `dlv_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Controller enable for pin inputs |
| pin_in | input | NPINS | Raw pin inputs |
| trig_lvl | input | NPINS | Per-pin trigger mode, 1 = level, 0 = edge |
| pin_mask | input | NPINS | Per-pin mask, 1 = masked |
| pin_vec | input | NPINS*VEC_W | Per-pin vector values, pin i at bits [i*VEC_W +: VEC_W] |
| bulk_set | input | NPINS | Strobe that sets requests of unmasked pins |
| bulk_clr | input | NPINS | Strobe that clears requests |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vec | input | VEC_W | Vector named by the end-of-interrupt |
| dlv_ready | input | 1 | Delivery logic accepts the offer |
| dlv_valid | output | 1 | A pin is offered |
| dlv_pin | output | $clog2(NPINS) | Number of the offered pin |

## Verification
The priority function is driven with edge bursts that raise one pin alone, the top pin alone, sparse and dense groups, and groups that contain masked pins. The delivered sequence must come out strictly descending and contain exactly the unmasked raised pins. Comparing the count with the first pin separates a wrong priority direction from lost or duplicated requests. Directed sequences hold the handshake off so that a request can be observed without being retired. These sequences separate level from edge behaviour on falling inputs and on retirement. They also separate an end-of-interrupt that finds its pin from one blocked by an unmatched vector, by a lower duplicate vector that is not in service, or by the excluded last pin.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int unsigned MAX_PINS = 64;

  // index of the most significant set bit; 0 when the vector is empty
  function automatic logic [5:0] top_bit(input logic [MAX_PINS-1:0] v);
    logic [5:0] idx;
    idx = '0;
    for (int i = 0; i < MAX_PINS; i++)
      if (v[i]) idx = 6'(i);
    return idx;
  endfunction

  // one-hot mark of the lowest set bit below position lim
  function automatic logic [MAX_PINS-1:0] low_onehot(input logic [MAX_PINS-1:0] v,
                                                     input int unsigned lim);
    logic [MAX_PINS-1:0] r;
    logic found;
    r = '0;
    found = 1'b0;
    for (int i = 0; i < MAX_PINS; i++)
      if (!found && i < int'(lim) && v[i]) begin
        r[i] = 1'b1;
        found = 1'b1;
      end
    return r;
  endfunction
endpackage

// File: rtl/irq_req_bank.sv
module irq_req_bank #(
  parameter int unsigned NPINS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [NPINS-1:0] pin_in,
  input  logic [NPINS-1:0] trig_lvl,
  input  logic [NPINS-1:0] pin_mask,
  input  logic [NPINS-1:0] bulk_set,
  input  logic [NPINS-1:0] bulk_clr,
  input  logic [NPINS-1:0] retire_bit,
  output logic [NPINS-1:0] irr,
  output logic [NPINS-1:0] req_set
);
  logic [NPINS-1:0] prev_in;
  logic [NPINS-1:0] req_clr;

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    logic rise, fall, open;
    assign open = enable & ~pin_mask[g];
    assign rise = pin_in[g] & ~prev_in[g];
    assign fall = ~pin_in[g] & prev_in[g];
    assign req_set[g] = (open & rise) | (bulk_set[g] & ~pin_mask[g]);
    assign req_clr[g] = (open & fall & trig_lvl[g]) | bulk_clr[g] | retire_bit[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_in <= '0;
      irr     <= '0;
    end else begin
      prev_in <= pin_in;
      irr     <= (irr & ~req_clr) | req_set;
    end
  end
endmodule

// File: rtl/irq_svc_bank.sv
module irq_svc_bank
  import irq_prio_pkg::*;
#(
  parameter int unsigned NPINS = 16,
  parameter int unsigned VEC_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NPINS*VEC_W-1:0] pin_vec,
  input  logic [NPINS-1:0]       trig_lvl,
  input  logic [NPINS-1:0]       retire_bit,
  input  logic                   eoi_valid,
  input  logic [VEC_W-1:0]       eoi_vec,
  output logic [NPINS-1:0]       isr,
  output logic [NPINS-1:0]       eoi_clr
);
  logic [NPINS-1:0]    vec_hit;
  logic [MAX_PINS-1:0] first_hit;
  logic [NPINS-1:0]    svc_set;

  for (genvar g = 0; g < NPINS; g++) begin : g_cmp
    assign vec_hit[g] = (pin_vec[g*VEC_W +: VEC_W] == eoi_vec);
  end

  // search excludes the last pin
  assign first_hit = low_onehot(MAX_PINS'(vec_hit), NPINS - 1);
  assign eoi_clr   = eoi_valid ? (first_hit[NPINS-1:0] & isr) : '0;
  assign svc_set   = retire_bit & trig_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) isr <= '0;
    else        isr <= (isr & ~eoi_clr) | svc_set;
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_prio_pkg::*;
#(
  parameter int unsigned NPINS = 16,
  localparam int unsigned PIN_W = $clog2(NPINS)
) (
  input  logic [NPINS-1:0] irr,
  input  logic [NPINS-1:0] isr,
  input  logic [NPINS-1:0] pin_mask,
  input  logic             dlv_ready,
  output logic             dlv_valid,
  output logic [PIN_W-1:0] dlv_pin,
  output logic [NPINS-1:0] retire_bit
);
  logic [NPINS-1:0] eligible;
  logic [5:0]       top;

  assign eligible   = irr & ~isr & ~pin_mask;
  assign top        = top_bit(MAX_PINS'(eligible));
  assign dlv_valid  = |eligible;
  assign dlv_pin    = top[PIN_W-1:0];
  assign retire_bit = (dlv_valid && dlv_ready) ? (NPINS'(1) << dlv_pin) : '0;
endmodule

// File: rtl/irq_prio_eoi.sv
module irq_prio_eoi #(
  parameter int unsigned NPINS = 16,
  parameter int unsigned VEC_W = 8,
  localparam int unsigned PIN_W = $clog2(NPINS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   enable,
  input  logic [NPINS-1:0]       pin_in,
  input  logic [NPINS-1:0]       trig_lvl,
  input  logic [NPINS-1:0]       pin_mask,
  input  logic [NPINS*VEC_W-1:0] pin_vec,
  input  logic [NPINS-1:0]       bulk_set,
  input  logic [NPINS-1:0]       bulk_clr,
  input  logic                   eoi_valid,
  input  logic [VEC_W-1:0]       eoi_vec,
  input  logic                   dlv_ready,
  output logic                   dlv_valid,
  output logic [PIN_W-1:0]       dlv_pin
);
  logic [NPINS-1:0] irr, isr, req_set, retire_bit, eoi_clr;

  irq_req_bank #(.NPINS(NPINS)) u_req (
    .clk(clk), .rst_n(rst_n), .enable(enable), .pin_in(pin_in),
    .trig_lvl(trig_lvl), .pin_mask(pin_mask), .bulk_set(bulk_set),
    .bulk_clr(bulk_clr), .retire_bit(retire_bit), .irr(irr), .req_set(req_set)
  );

  irq_svc_bank #(.NPINS(NPINS), .VEC_W(VEC_W)) u_svc (
    .clk(clk), .rst_n(rst_n), .pin_vec(pin_vec), .trig_lvl(trig_lvl),
    .retire_bit(retire_bit), .eoi_valid(eoi_valid), .eoi_vec(eoi_vec),
    .isr(isr), .eoi_clr(eoi_clr)
  );

  irq_pick #(.NPINS(NPINS)) u_pick (
    .irr(irr), .isr(isr), .pin_mask(pin_mask), .dlv_ready(dlv_ready),
    .dlv_valid(dlv_valid), .dlv_pin(dlv_pin), .retire_bit(retire_bit)
  );
endmodule

// File: rtl/irq_prio_eoi_chk.sv
module irq_prio_eoi_chk #(
  parameter int unsigned NPINS = 16,
  localparam int unsigned PIN_W = $clog2(NPINS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic [NPINS-1:0] pin_mask,
  input logic [NPINS-1:0] trig_lvl,
  input logic [NPINS-1:0] bulk_set,
  input logic             dlv_valid,
  input logic             dlv_ready,
  input logic [PIN_W-1:0] dlv_pin,
  input logic [NPINS-1:0] irr,
  input logic [NPINS-1:0] isr,
  input logic [NPINS-1:0] req_set,
  input logic [NPINS-1:0] eoi_clr
);
  assert_offer_eligible_R1: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid |-> (irr[dlv_pin] && !isr[dlv_pin] && !pin_mask[dlv_pin]));

  assert_retire_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_valid && dlv_ready) |=> (!irr[$past(dlv_pin)] || $past(req_set[dlv_pin])));

  assert_level_in_service_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_valid && dlv_ready && trig_lvl[dlv_pin]) |=> isr[$past(dlv_pin)]);

  assert_edge_no_service_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_valid && dlv_ready && !trig_lvl[dlv_pin]) |=> !isr[$past(dlv_pin)]);

  assert_disabled_no_new_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && bulk_set == '0) |=> ((irr & ~$past(irr)) == '0));

  assert_eoi_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(eoi_clr));

  assert_service_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_clr == '0) |=> ((~isr & $past(isr)) == '0));
endmodule

bind irq_prio_eoi irq_prio_eoi_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .pin_mask(pin_mask),
  .trig_lvl(trig_lvl), .bulk_set(bulk_set), .dlv_valid(dlv_valid),
  .dlv_ready(dlv_ready), .dlv_pin(dlv_pin), .irr(irr), .isr(isr),
  .req_set(req_set), .eoi_clr(eoi_clr)
);

// File: tb/irq_prio_eoi_bench.sv
module irq_prio_eoi_bench;
  localparam int NP = 16;
  localparam int VW = 8;
  localparam int PW = $clog2(NP);

  typedef struct packed {
    logic [15:0] pat;
    logic [15:0] msk;
    logic [7:0]  cnt;
    logic [7:0]  first;
  } row_t;

  localparam int NROWS = 7;
  localparam row_t ROWS [NROWS] = '{
    '{16'h0001, 16'h0000, 8'd1,  8'd0},
    '{16'h8000, 16'h0000, 8'd1,  8'd15},
    '{16'h0F0F, 16'h0000, 8'd8,  8'd11},
    '{16'hFFFF, 16'h8000, 8'd15, 8'd14},
    '{16'h00A5, 16'h0080, 8'd3,  8'd5},
    '{16'hC003, 16'hC000, 8'd2,  8'd1},
    '{16'h0000, 16'h0000, 8'd0,  8'd0}
  };

  logic clk = 0, rst_n = 0, enable = 0;
  logic [NP-1:0] pin_in = '0, trig_lvl = '0, pin_mask = '0, bulk_set = '0, bulk_clr = '0;
  logic [NP*VW-1:0] pin_vec;
  logic [VW-1:0] vec_tab [NP];
  logic eoi_valid = 0, dlv_ready = 0;
  logic [VW-1:0] eoi_vec = '0;
  logic dlv_valid;
  logic [PW-1:0] dlv_pin;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  always_comb
    for (int i = 0; i < NP; i++) pin_vec[i*VW +: VW] = vec_tab[i];

  irq_prio_eoi #(.NPINS(NP), .VEC_W(VW)) u_irq_prio_eoi (
    .clk(clk), .rst_n(rst_n), .enable(enable), .pin_in(pin_in),
    .trig_lvl(trig_lvl), .pin_mask(pin_mask), .pin_vec(pin_vec),
    .bulk_set(bulk_set), .bulk_clr(bulk_clr), .eoi_valid(eoi_valid),
    .eoi_vec(eoi_vec), .dlv_ready(dlv_ready), .dlv_valid(dlv_valid),
    .dlv_pin(dlv_pin)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // offer state: -1 when nothing offered, else pin number
  function automatic int offer();
    return dlv_valid ? int'(dlv_pin) : -1;
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic ready_pulse();
    dlv_ready = 1; tick(); dlv_ready = 0;
  endtask

  task automatic send_eoi(input logic [VW-1:0] v);
    eoi_valid = 1; eoi_vec = v; tick(); eoi_valid = 0; tick();
  endtask

  initial begin
    for (int i = 0; i < NP; i++) vec_tab[i] = VW'(8'h20 + i);
    repeat (3) tick();
    rst_n = 1;
    tick();
    chk(offer() == -1, "R10 reset idle", offer(), -1);
    enable = 1;

    // table walk: edge bursts with ready held high
    dlv_ready = 1;
    for (int r = 0; r < NROWS; r++) begin
      int got [NP];
      int n;
      bit desc;
      n = 0;
      desc = 1;
      pin_mask = ROWS[r].msk;
      pin_in = ROWS[r].pat;
      for (int c = 0; c < 24; c++) begin
        tick();
        if (dlv_valid && n < NP) begin
          got[n] = int'(dlv_pin);
          if (n > 0 && got[n] >= got[n-1]) desc = 0;
          n++;
        end
        pin_in = '0;
      end
      chk(n == int'(ROWS[r].cnt), "R1 R2 delivery count", n, int'(ROWS[r].cnt));
      if (n > 0) chk(got[0] == int'(ROWS[r].first), "R1 highest first", got[0], int'(ROWS[r].first));
      chk(desc, "R1 descending order", int'(desc), 1);
      pin_mask = '0;
    end
    dlv_ready = 0;
    tick();

    // level pin: in service until EOI
    trig_lvl[3] = 1;
    pin_in[3] = 1; tick();
    chk(offer() == 3, "R4 level rise sets", offer(), 3);
    ready_pulse(); tick();
    chk(offer() == -1, "R3 level retired enters service", offer(), -1);
    pin_in[3] = 0; tick(); pin_in[3] = 1; tick();
    chk(offer() == -1, "R3 in-service blocks re-request", offer(), -1);
    send_eoi(8'h99);
    chk(offer() == -1, "R9 unmatched eoi ignored", offer(), -1);
    send_eoi(8'h23);
    chk(offer() == 3, "R8 eoi releases pin", offer(), 3);
    ready_pulse(); pin_in[3] = 0; tick();
    send_eoi(8'h23);
    trig_lvl[3] = 0;

    // level fall clears
    trig_lvl[2] = 1;
    pin_in[2] = 1; tick();
    chk(offer() == 2, "R4 level pending", offer(), 2);
    pin_in[2] = 0; tick();
    chk(offer() == -1, "R4 level fall clears", offer(), -1);
    trig_lvl[2] = 0;

    // edge fall no effect, no service
    pin_in[5] = 1; tick();
    pin_in[5] = 0; tick();
    chk(offer() == 5, "R5 edge fall keeps request", offer(), 5);
    ready_pulse();
    chk(offer() == -1, "R2 retired edge request", offer(), -1);
    pin_in[5] = 1; tick();
    chk(offer() == 5, "R3 edge pin not in service", offer(), 5);
    ready_pulse(); pin_in[5] = 0; tick();

    // disable and mask gating
    enable = 0; pin_in[6] = 1; tick();
    chk(offer() == -1, "R6 disabled input ignored", offer(), -1);
    enable = 1; tick();
    chk(offer() == -1, "R6 not recalled on enable", offer(), -1);
    pin_in[6] = 0;
    pin_mask[7] = 1; pin_in[7] = 1; tick();
    pin_mask[7] = 0; tick();
    chk(offer() == -1, "R6 masked input ignored", offer(), -1);
    pin_in[7] = 0; tick();

    // mask hides a pending request
    bulk_set[9] = 1; tick(); bulk_set = '0;
    chk(offer() == 9, "R7 bulk set", offer(), 9);
    pin_mask[9] = 1; tick();
    chk(offer() == -1, "R1 masked not eligible", offer(), -1);
    pin_mask[9] = 0; tick();
    chk(offer() == 9, "R1 unmask restores offer", offer(), 9);
    bulk_clr[9] = 1; tick(); bulk_clr = '0;
    chk(offer() == -1, "R7 bulk clear", offer(), -1);
    pin_mask[10] = 1; bulk_set[10] = 1; tick(); bulk_set = '0; pin_mask[10] = 0; tick();
    chk(offer() == -1, "R7 bulk set on masked ignored", offer(), -1);
    bulk_set[11] = 1; bulk_clr[11] = 1; tick(); bulk_set = '0; bulk_clr = '0;
    chk(offer() == 11, "R7 set wins over clear", offer(), 11);
    bulk_clr[11] = 1; tick(); bulk_clr = '0;

    // duplicate vectors: lowest match decides
    vec_tab[1] = 8'h40; vec_tab[6] = 8'h40; trig_lvl[6] = 1;
    pin_in[6] = 1; tick(); ready_pulse();
    pin_in[6] = 0; tick(); pin_in[6] = 1; tick();
    send_eoi(8'h40);
    chk(offer() == -1, "R9 lower duplicate not in service", offer(), -1);
    vec_tab[1] = 8'h01;
    send_eoi(8'h40);
    chk(offer() == 6, "R8 match after vector change", offer(), 6);
    ready_pulse(); pin_in[6] = 0; tick(); send_eoi(8'h40);
    trig_lvl[6] = 0;

    // last pin excluded from the search
    vec_tab[15] = 8'h77; trig_lvl[15] = 1;
    pin_in[15] = 1; tick(); ready_pulse();
    pin_in[15] = 0; tick(); pin_in[15] = 1; tick();
    send_eoi(8'h77);
    chk(offer() == -1, "R9 last pin never released", offer(), -1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule